// File: doc/BRIEF.md
# Halt and Wakeup Power Controller

This block decides when the core of a small microcontroller runs. It keeps the core clock enable, the timer enables, the oscillator enable and the watchdog enable. Software can park the device in a deep stop state, in which the oscillator is off, or in a light sleep state, in which the oscillator and one timer keep running. A wakeup event or reset brings the device back.

Leaving the deep stop state restarts the oscillator. The core clock is then held off until a stabilization timer has counted down. That timer is clocked by a prescaled tick, one tick per `DIV` oscillator cycles, and only counts while the oscillator-valid input says the oscillator is usable. In RC clock mode a configuration bit decides whether this delay is applied. The light sleep state is left at once, because the oscillator never stopped. The watchdog and the clock monitor are outside this block. It only drives their enable outputs.

Top module: `halt_pwr_ctrl`

## Requirements
- R1: After reset is released the core clock enable, oscillator enable, T0 enable and watchdog enable are 1, the halt flag is 0, and the delay-select bit is 0.
- R2: In the run state, a halt write with data 1 and `halt_dis_i`=0 makes the halt flag 1 and drives the core clock, T0 and oscillator enables to 0 after the next clock edge. A halt write with data 0 has no effect.
- R3: With `halt_dis_i`=1 a halt write with data 1 is ignored: the halt flag stays 0 and the core clock stays enabled.
- R4: The stop state is left when `wake_req_i` is 1 at a clock edge, or when `wake_pin_i` is 1 at a clock edge after being 0 at the previous edge. A wake pin held steadily high does not cause an exit.
- R5: When the delay applies (`rc_mode_i`=0, or `rc_mode_i`=1 with the delay-select bit at 1), the oscillator enable is 1 and the core clock enable is 0 from the exit edge until exactly `DLY_CNT`*`DIV` oscillator-valid clock edges later. At that edge the core clock enable becomes 1.
- R6: Clock edges with `osc_valid_i`=0 are not counted by the stabilization delay.
- R7: With `rc_mode_i`=1 and the delay-select bit at 0, a stop exit enables the core clock at the exit edge.
- R8: The watchdog enable is 0 whenever the halt flag is 1. `clkmon_en_o` follows `clkmon_en_i` in every state.
- R9: In the run state an idle request without a halt write enters light sleep. There the core clock is 0 and the T0, oscillator and watchdog enables are 1. A wake request or a wake pin rise returns the controller to run at the next edge.
- R10: Asserting `rst_ni` low returns the controller to run at once, from any state, with the halt flag cleared.
- R11: A halt write with data 1 and an idle request in the same cycle enter the stop state.
- R12: The delay-select bit is written from `cfg_clkdly_i` when `cfg_wr_i` is 1 in the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| halt_dis_i | input | 1 | Strap: halt entry disabled |
| rc_mode_i | input | 1 | Strap: 1 = RC oscillator, 0 = crystal |
| halt_wr_i | input | 1 | Halt flag write strobe |
| halt_wdata_i | input | 1 | Halt flag write data |
| cfg_wr_i | input | 1 | Delay-select bit write strobe |
| cfg_clkdly_i | input | 1 | Delay-select bit write data |
| idle_req_i | input | 1 | Light sleep request |
| wake_req_i | input | 1 | Multi-input wakeup request |
| wake_pin_i | input | 1 | Wake pin, acts on rising edge |
| osc_valid_i | input | 1 | Oscillator amplitude valid |
| clkmon_en_i | input | 1 | Clock monitor enable from configuration |
| core_clk_en_o | output | 1 | Core clock enable |
| t0_en_o | output | 1 | Timer T0 enable |
| osc_en_o | output | 1 | Oscillator enable |
| wdog_en_o | output | 1 | Watchdog enable |
| clkmon_en_o | output | 1 | Clock monitor enable |
| halt_flag_o | output | 1 | Halt flag read value |

## Verification
The assertions assume that the straps `halt_dis_i` and `rc_mode_i` only change while reset is held. They also assume that halt writes and configuration writes are only issued while the core clock is enabled. The halt-disable property relies on the straps being static. The bench changes straps only across a reset pulse, and it lowers write strobes one cycle after raising them from the run state. Sweeps over mode, delay bit and oscillator-valid patterns compare exit latency against `DLY_CNT`*`DIV` valid edges.

// File: rtl/hpc_pkg.sv
`timescale 1ns/1ps
package hpc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_HALT = 2'd2,
    ST_STAB = 2'd3
  } hpc_state_e;
endpackage

// File: rtl/hpc_prescaler.sv
`timescale 1ns/1ps
module hpc_prescaler #(
  parameter int unsigned DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hpc_stab_timer.sv
`timescale 1ns/1ps
module hpc_stab_timer #(
  parameter int unsigned DLY_CNT = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(DLY_CNT + 1);
  localparam logic [CW-1:0] INIT = CW'(DLY_CNT);

  logic [CW-1:0] cnt_q;

  // expires on the tick that would take the count to zero
  assign done_o = tick_i && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= INIT;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/hpc_edge_det.sv
`timescale 1ns/1ps
module hpc_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic pin_q;

  assign rise_o = pin_i && !pin_q;

  // reset high so a pin already high after reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b1;
    else         pin_q <= pin_i;
  end
endmodule

// File: rtl/halt_pwr_ctrl.sv
`timescale 1ns/1ps
module halt_pwr_ctrl
  import hpc_pkg::*;
#(
  parameter int unsigned DIV     = 10,
  parameter int unsigned DLY_CNT = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_dis_i,
  input  logic rc_mode_i,
  input  logic halt_wr_i,
  input  logic halt_wdata_i,
  input  logic cfg_wr_i,
  input  logic cfg_clkdly_i,
  input  logic idle_req_i,
  input  logic wake_req_i,
  input  logic wake_pin_i,
  input  logic osc_valid_i,
  input  logic clkmon_en_i,
  output logic core_clk_en_o,
  output logic t0_en_o,
  output logic osc_en_o,
  output logic wdog_en_o,
  output logic clkmon_en_o,
  output logic halt_flag_o
);
  hpc_state_e state_q, state_d;
  logic clkdly_q;
  logic pin_rise, wake_any, need_dly, halt_go;
  logic stab_load, pre_en, pre_tick, stab_done;

  hpc_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (wake_pin_i),
    .rise_o (pin_rise)
  );

  hpc_prescaler #(.DIV(DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (stab_load),
    .en_i   (pre_en),
    .tick_o (pre_tick)
  );

  hpc_stab_timer #(.DLY_CNT(DLY_CNT)) u_stab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (stab_load),
    .tick_i (pre_tick),
    .done_o (stab_done)
  );

  assign wake_any = wake_req_i || pin_rise;
  // crystal always waits; RC waits only when selected
  assign need_dly = !rc_mode_i || clkdly_q;
  assign halt_go  = halt_wr_i && halt_wdata_i && !halt_dis_i;
  assign stab_load = (state_q == ST_HALT) && wake_any && need_dly;
  assign pre_en    = (state_q == ST_STAB) && osc_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (halt_go)         state_d = ST_HALT;
        else if (idle_req_i) state_d = ST_IDLE;
      end
      ST_IDLE: if (wake_any) state_d = ST_RUN;
      ST_HALT: if (wake_any) state_d = need_dly ? ST_STAB : ST_RUN;
      ST_STAB: if (stab_done) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             clkdly_q <= 1'b0;
    else if (cfg_wr_i && state_q == ST_RUN)  clkdly_q <= cfg_clkdly_i;
  end

  always_comb begin
    core_clk_en_o = (state_q == ST_RUN);
    t0_en_o       = (state_q == ST_RUN) || (state_q == ST_IDLE);
    wdog_en_o     = (state_q == ST_RUN) || (state_q == ST_IDLE);
    osc_en_o      = (state_q != ST_HALT);
    halt_flag_o   = (state_q == ST_HALT) || (state_q == ST_STAB);
    clkmon_en_o   = clkmon_en_i;
  end
endmodule

// File: rtl/halt_pwr_chk.sv
`timescale 1ns/1ps
module halt_pwr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic halt_dis_i,
  input logic rc_mode_i,
  input logic halt_wr_i,
  input logic halt_wdata_i,
  input logic idle_req_i,
  input logic wake_req_i,
  input logic osc_valid_i,
  input logic clkdly_i,
  input logic core_clk_en_o,
  input logic t0_en_o,
  input logic osc_en_o,
  input logic wdog_en_o,
  input logic halt_flag_o
);
  // R2
  halt_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_clk_en_o && halt_wr_i && halt_wdata_i && !halt_dis_i)
      |=> (halt_flag_o && !core_clk_en_o && !osc_en_o && !t0_en_o));

  // R3
  halt_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_dis_i && !halt_flag_o) |=> !halt_flag_o);

  // R8
  wdog_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_flag_o |-> !wdog_en_o);

  // R5
  stab_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_flag_o && osc_en_o) |-> !core_clk_en_o);

  // R6
  stab_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_flag_o && osc_en_o && !osc_valid_i) |=> halt_flag_o);

  // R7
  rc_nodly_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && wake_req_i && rc_mode_i && !clkdly_i) |=> core_clk_en_o);

  // R9
  idle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_clk_en_o && t0_en_o && wake_req_i) |=> core_clk_en_o);

  // R11
  halt_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_clk_en_o && halt_wr_i && halt_wdata_i && !halt_dis_i && idle_req_i)
      |=> !t0_en_o);
endmodule

bind halt_pwr_ctrl halt_pwr_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .halt_dis_i    (halt_dis_i),
  .rc_mode_i     (rc_mode_i),
  .halt_wr_i     (halt_wr_i),
  .halt_wdata_i  (halt_wdata_i),
  .idle_req_i    (idle_req_i),
  .wake_req_i    (wake_req_i),
  .osc_valid_i   (osc_valid_i),
  .clkdly_i      (clkdly_q),
  .core_clk_en_o (core_clk_en_o),
  .t0_en_o       (t0_en_o),
  .osc_en_o      (osc_en_o),
  .wdog_en_o     (wdog_en_o),
  .halt_flag_o   (halt_flag_o)
);

// File: tb/sim_halt_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_halt_pwr_ctrl;
  localparam int DIV = 10;
  localparam int DLY = 256;
  localparam int EXP = DIV * DLY;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic halt_dis_i = 0, rc_mode_i = 0, halt_wr_i = 0, halt_wdata_i = 0;
  logic cfg_wr_i = 0, cfg_clkdly_i = 0, idle_req_i = 0, wake_req_i = 0;
  logic wake_pin_i = 0, osc_valid_i = 1, clkmon_en_i = 1;
  logic core_clk_en_o, t0_en_o, osc_en_o, wdog_en_o, clkmon_en_o, halt_flag_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  halt_pwr_ctrl #(.DIV(DIV), .DLY_CNT(DLY)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    step();
    rst_ni = 1'b1;
    step();
  endtask

  task automatic halt_write(input logic d);
    halt_wr_i = 1; halt_wdata_i = d;
    step();
    halt_wr_i = 0; halt_wdata_i = 0;
  endtask

  task automatic set_clkdly(input logic d);
    cfg_wr_i = 1; cfg_clkdly_i = d;
    step();
    cfg_wr_i = 0;
  endtask

  // pulse wake_req, count edges until the core clock returns
  task automatic wake_measure(output int n, input int vmod);
    int valid_cnt;
    wake_req_i = 1;
    step();
    wake_req_i = 0;
    n = 0;
    valid_cnt = 0;
    while (!core_clk_en_o && n < 4 * EXP) begin
      if (n == 0) begin
        chk("R5 osc_en in stab", osc_en_o, 1);
        chk("R8 wdog off in stab", wdog_en_o, 0);
      end
      osc_valid_i = (vmod == 0) ? 1'b1 : ((n % vmod) != 0);
      if (osc_valid_i) valid_cnt++;
      step();
      n++;
    end
    osc_valid_i = 1;
    if (vmod != 0) n = valid_cnt;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    // R1
    chk("R1 core_clk_en", core_clk_en_o, 1);
    chk("R1 halt_flag", halt_flag_o, 0);
    chk("R1 osc_en", osc_en_o, 1);
    chk("R1 t0_en", t0_en_o, 1);
    chk("R1 wdog_en", wdog_en_o, 1);

    // R3: strapped disable
    halt_dis_i = 1;
    do_reset();
    halt_write(1);
    chk("R3 halt_flag", halt_flag_o, 0);
    chk("R3 core_clk_en", core_clk_en_o, 1);
    halt_dis_i = 0;
    do_reset();

    // R2: write 0 no effect, write 1 halts
    halt_write(0);
    chk("R2 write0 flag", halt_flag_o, 0);
    chk("R2 write0 core", core_clk_en_o, 1);
    halt_write(1);
    chk("R2 halt_flag", halt_flag_o, 1);
    chk("R2 core off", core_clk_en_o, 0);
    chk("R2 t0 off", t0_en_o, 0);
    chk("R2 osc off", osc_en_o, 0);
    chk("R8 wdog off in halt", wdog_en_o, 0);
    for (int v = 0; v < 2; v++) begin
      clkmon_en_i = v[0];
      #0.5;
      chk("R8 clkmon follows in halt", clkmon_en_o, v);
    end
    clkmon_en_i = 1;

    // R4: steady-high pin does not wake; rising edge does (crystal -> delay)
    wake_pin_i = 1;
    step();
    step();
    chk("R4 pin first high wakes", osc_en_o, 1);
    do_reset();
    wake_pin_i = 1;
    step();
    halt_write(1);
    for (int i = 0; i < 5; i++) step();
    chk("R4 steady pin stays halted", osc_en_o, 0);
    wake_pin_i = 0;
    step();
    chk("R4 pin low stays halted", osc_en_o, 0);
    wake_pin_i = 1;
    step();
    chk("R4 pin rise leaves halt", osc_en_o, 1);
    wake_pin_i = 0;
    do_reset();

    // R5/R12: delay sweep over rc mode and delay bit
    for (int m = 0; m < 4; m++) begin
      logic rc, dly;
      rc = m[1]; dly = m[0];
      rc_mode_i = rc;
      do_reset();
      set_clkdly(dly);
      halt_write(1);
      wake_measure(n, 0);
      if (!rc || dly) chk($sformatf("R5 R12 latency rc=%0d dly=%0d", rc, dly), n, EXP);
      else            chk("R7 rc no delay latency", n, 0);
      chk("R5 halt flag cleared after wake", halt_flag_o, 0);
    end

    // R6: invalid oscillator cycles not counted
    for (int vm = 2; vm <= 4; vm++) begin
      rc_mode_i = 0;
      do_reset();
      halt_write(1);
      wake_measure(n, vm);
      chk($sformatf("R6 valid edges mod %0d", vm), n, EXP);
    end

    // R1/R7: delay bit cleared by reset
    rc_mode_i = 1;
    do_reset();
    set_clkdly(1);
    do_reset();
    halt_write(1);
    wake_req_i = 1;
    step();
    wake_req_i = 0;
    chk("R1 R7 delay bit cleared by reset", core_clk_en_o, 1);

    // R12: write ignored outside run
    do_reset();
    halt_write(1);
    set_clkdly(1);
    wake_req_i = 1;
    step();
    wake_req_i = 0;
    chk("R12 cfg write ignored in halt", core_clk_en_o, 1);

    // R9: idle entry and both exits
    rc_mode_i = 0;
    do_reset();
    for (int e = 0; e < 2; e++) begin
      idle_req_i = 1;
      step();
      idle_req_i = 0;
      chk("R9 idle core off", core_clk_en_o, 0);
      chk("R9 idle t0 on", t0_en_o, 1);
      chk("R9 idle osc on", osc_en_o, 1);
      chk("R9 idle wdog on", wdog_en_o, 1);
      chk("R9 idle flag", halt_flag_o, 0);
      step();
      chk("R9 idle holds", core_clk_en_o, 0);
      if (e == 0) wake_req_i = 1; else wake_pin_i = 1;
      step();
      wake_req_i = 0;
      chk("R9 idle exit immediate", core_clk_en_o, 1);
      wake_pin_i = 0;
      step();
    end

    // R11: halt wins over idle
    halt_wr_i = 1; halt_wdata_i = 1; idle_req_i = 1;
    step();
    halt_wr_i = 0; halt_wdata_i = 0; idle_req_i = 0;
    chk("R11 halt priority flag", halt_flag_o, 1);
    chk("R11 halt priority t0", t0_en_o, 0);

    // R10: async reset from halt and from stabilization
    rst_ni = 0;
    #1;
    chk("R10 reset from halt core", core_clk_en_o, 1);
    chk("R10 reset from halt flag", halt_flag_o, 0);
    step();
    rst_ni = 1;
    step();
    halt_write(1);
    wake_req_i = 1;
    step();
    wake_req_i = 0;
    for (int i = 0; i < 20; i++) step();
    chk("R10 in stab before reset", core_clk_en_o, 0);
    rst_ni = 0;
    #1;
    chk("R10 reset from stab core", core_clk_en_o, 1);
    chk("R10 reset from stab flag", halt_flag_o, 0);
    step();
    rst_ni = 1;
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule